// File: doc/BRIEF.md
# Pipelined Microsequencer with Branch Cancel

This block sequences a micro-programmed controller whose fetch runs one cycle ahead of execution. A micro-instruction register sits at the control-store output, so a word read in one cycle drives the datapath in the next. The control-store address register (CSAR) is presented on `cs_addr`, and the store returns the addressed word combinationally on `cs_data`. The command half of the executing word goes to the datapath on `cmd`, qualified by `cmd_valid`.

Datapath status comes back on `flag_zero` and `flag_carry`. These raw flags are captured in a condition-code register at the end of every executed cycle. A conditional jump therefore tests the flags of an instruction that ran earlier, never its own flags.

Because fetch is one cycle ahead, a taken jump always finds the next sequential word already in flight. The block squashes that word: it enters the instruction register as a no-op with `cmd_valid` low. Its sequencing field is disregarded, and its flags are not captured. The cost is one dead cycle per taken jump, and the micro-programmer needs no delay slot.

Top module: `useq_pipe`

## Requirements
- R1: While `rst_n` is low, `cs_addr` is 0, `cmd_valid` is 0, `cmd` is 0 and both held flags are 0. After `rst_n` rises, the block stays in that state through two more rising edges, and it first advances on the third.
- R2: A word is laid out as command in bits 31:16, sequencing code in bits 15:12 and address operand in bits 11:0. Without a taken jump, `cs_addr` advances by one (mod 4096) each cycle. In the next cycle, `cmd` shows bits 31:16 of the word read at the previous `cs_addr`, with `cmd_valid` high.
- R3: Code bits 13:12 = 01 selects an absolute jump. When it is taken, `cs_addr` in the following cycle equals the operand of the executing word.
- R4: Code bits 13:12 = 10 selects a relative jump. When it is taken, the new `cs_addr` is the address the jumping word was fetched from plus the operand, modulo 4096.
- R5: In the cycle after a taken jump, the squashed word appears with `cmd_valid` low and `cmd` all zero.
- R6: A squashed word's sequencing code is ignored, and `cs_addr` keeps stepping by one from the jump target.
- R7: Code bits 15:14 select the jump condition: 00 = always, 01 = held zero flag set, 10 = held carry flag set, 11 = held zero flag clear. Each cycle with `cmd_valid` high loads the raw flags into the held flags, and a jump tests the held value, not the raw flags of its own cycle.
- R8: Flags presented while `cmd_valid` is low are not captured, so a jump that follows a squashed word tests the flags of the last valid word.
- R9: Code bits 13:12 = 11 steps by one, like 00, whatever the condition bits hold.
- R10: A jump whose condition is false steps by one and squashes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted through a synchronizer |
| cs_addr | output | 12 | Control-store read address (CSAR) |
| cs_data | input | 32 | Control-store word at `cs_addr`, same cycle |
| cmd | output | 16 | Command field of the executing word |
| cmd_valid | output | 1 | High when `cmd` is a live command, low for a squashed or reset slot |
| flag_zero | input | 1 | Raw zero flag from the datapath for the current command |
| flag_carry | input | 1 | Raw carry flag from the datapath for the current command |

## Verification
Two pairs of events can land in one cycle. In the first, a taken jump is executing while the word behind it also carries a jump. Directed code places absolute jumps to far-off addresses in each shadow slot, and the bench checks that `cs_addr` follows only the first jump. In the second, a conditional jump executes while its own raw flags are being captured, or right after a squashed slot whose garbage flags are all ones. Here the bench judges the branch against the held flags of the last valid word. A cycle-level reference model checks every cycle under random words and random flags.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int NXT_W = 4;

  typedef enum logic [1:0] {
    NM_STEP  = 2'b00,
    NM_ABS   = 2'b01,
    NM_REL   = 2'b10,
    NM_SPARE = 2'b11
  } nxt_mode_e;

  typedef enum logic [1:0] {
    NC_ALWAYS  = 2'b00,
    NC_ZERO    = 2'b01,
    NC_CARRY   = 2'b10,
    NC_NONZERO = 2'b11
  } nxt_cond_e;

  typedef struct packed {
    logic zero;
    logic carry;
  } ccode_t;

  function automatic logic cond_met(input nxt_cond_e c, input ccode_t cc);
    logic r;
    case (c)
      NC_ALWAYS:  r = 1'b1;
      NC_ZERO:    r = cc.zero;
      NC_CARRY:   r = cc.carry;
      NC_NONZERO: r = ~cc.zero;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = 1'b1;
    end else begin : g_chain
      always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign srst_n = sr_q[STAGES-1];

endmodule

// File: rtl/useq_uir.sv
module useq_uir #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              squash,
  output logic [WORD_W-1:0] ir_word,
  output logic [ADDR_W-1:0] ir_pc,
  output logic              ir_valid
);

  logic [WORD_W-1:0] word_d;
  logic [ADDR_W-1:0] pc_d;
  logic              valid_d;

  // a squashed slot enters as an all-zero no-op
  always_comb begin
    word_d  = squash ? '0 : fetch_word;
    pc_d    = fetch_pc;
    valid_d = ~squash;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ir_word  <= '0;
      ir_pc    <= '0;
      ir_valid <= 1'b0;
    end else begin
      ir_word  <= word_d;
      ir_pc    <= pc_d;
      ir_valid <= valid_d;
    end
  end

endmodule

// File: rtl/useq_ccr.sv
module useq_ccr
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  logic   load_en,
  input  logic   zero_in,
  input  logic   carry_in,
  output ccode_t cc_q
);

  ccode_t cc_d;

  always_comb begin
    cc_d = cc_q;
    if (load_en) begin
      cc_d.zero  = zero_in;
      cc_d.carry = carry_in;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cc_q <= '0;
    else         cc_q <= cc_d;
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] csar,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic [ADDR_W-1:0] exec_tgt,
  input  logic [NXT_W-1:0]  exec_nxt,
  input  logic              exec_valid,
  input  ccode_t            cc,
  output logic [ADDR_W-1:0] csar_next,
  output logic              taken
);

  nxt_mode_e         mode;
  nxt_cond_e         cond;
  logic              is_jump;
  logic [ADDR_W-1:0] target;

  always_comb begin
    mode      = nxt_mode_e'(exec_nxt[1:0]);
    cond      = nxt_cond_e'(exec_nxt[3:2]);
    is_jump   = (mode == NM_ABS) || (mode == NM_REL);
    taken     = exec_valid && is_jump && cond_met(cond, cc);
    target    = (mode == NM_REL) ? exec_pc + exec_tgt : exec_tgt;
    csar_next = taken ? target : csar + 1'b1;
  end

endmodule

// File: rtl/useq_pipe.sv
module useq_pipe
  import useq_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic [ADDR_W-1:0]               cs_addr,
  input  logic [CMD_W+NXT_W+ADDR_W-1:0]   cs_data,
  output logic [CMD_W-1:0]                cmd,
  output logic                            cmd_valid,
  input  logic                            flag_zero,
  input  logic                            flag_carry
);

  localparam int WORD_W  = CMD_W + NXT_W + ADDR_W;
  localparam int NXT_LSB = ADDR_W;
  localparam int CMD_LSB = ADDR_W + NXT_W;

  logic              srst_n;
  logic [ADDR_W-1:0] csar_q;
  logic [ADDR_W-1:0] csar_d;
  logic              taken;
  logic [WORD_W-1:0] ir_word;
  logic [ADDR_W-1:0] ir_pc;
  logic              ir_valid;
  logic [CMD_W-1:0]  ir_cmd;
  logic [NXT_W-1:0]  ir_nxt;
  logic [ADDR_W-1:0] ir_tgt;
  ccode_t            cc;

  useq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // fetch stage: CSAR
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) csar_q <= '0;
    else         csar_q <= csar_d;
  end

  // execute stage: micro-instruction register
  useq_uir #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_uir (
    .clk        (clk),
    .arst_n     (srst_n),
    .fetch_word (cs_data),
    .fetch_pc   (csar_q),
    .squash     (taken),
    .ir_word    (ir_word),
    .ir_pc      (ir_pc),
    .ir_valid   (ir_valid)
  );

  always_comb begin
    ir_cmd = ir_word[CMD_LSB +: CMD_W];
    ir_nxt = ir_word[NXT_LSB +: NXT_W];
    ir_tgt = ir_word[ADDR_W-1:0];
  end

  useq_ccr u_ccr (
    .clk      (clk),
    .arst_n   (srst_n),
    .load_en  (ir_valid),
    .zero_in  (flag_zero),
    .carry_in (flag_carry),
    .cc_q     (cc)
  );

  useq_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .csar       (csar_q),
    .exec_pc    (ir_pc),
    .exec_tgt   (ir_tgt),
    .exec_nxt   (ir_nxt),
    .exec_valid (ir_valid),
    .cc         (cc),
    .csar_next  (csar_d),
    .taken      (taken)
  );

  assign cs_addr   = csar_q;
  assign cmd       = ir_cmd;
  assign cmd_valid = ir_valid;

endmodule

// File: rtl/useq_pipe_chk.sv
module useq_pipe_chk
  import useq_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] cs_addr,
  input logic [CMD_W-1:0]  cmd,
  input logic              cmd_valid,
  input logic              taken,
  input logic [NXT_W-1:0]  ir_nxt,
  input logic [ADDR_W-1:0] ir_tgt,
  input logic [ADDR_W-1:0] ir_pc,
  input ccode_t            cc
);

  assert_step_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !taken |=> cs_addr == ADDR_W'($past(cs_addr) + 1'b1));

  assert_live_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !taken |=> cmd_valid);

  assert_abs_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (taken && ir_nxt[1:0] == NM_ABS) |=> cs_addr == $past(ir_tgt));

  assert_rel_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (taken && ir_nxt[1:0] == NM_REL) |=> cs_addr == ADDR_W'($past(ir_pc) + $past(ir_tgt)));

  assert_squash_R5: assert property (@(posedge clk) disable iff (!srst_n)
    taken |=> !cmd_valid);

  assert_nop_cmd_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !cmd_valid |-> cmd == '0);

  assert_dead_slot_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !cmd_valid |-> !taken);

  assert_zero_test_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && ir_nxt[3:2] == NC_ZERO && ir_nxt[1:0] == NM_ABS && !cc.zero)
      |=> cs_addr == ADDR_W'($past(cs_addr) + 1'b1));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !cmd_valid |=> $stable(cc));

endmodule

bind useq_pipe useq_pipe_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .cs_addr   (cs_addr),
  .cmd       (cmd),
  .cmd_valid (cmd_valid),
  .taken     (taken),
  .ir_nxt    (ir_nxt),
  .ir_tgt    (ir_tgt),
  .ir_pc     (ir_pc),
  .cc        (cc)
);

// File: tb/useq_pipe_tb.sv
module useq_pipe_tb;

  localparam int CMD_W  = 16;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cs_addr;
  logic [WORD_W-1:0] cs_data;
  logic [CMD_W-1:0]  cmd;
  logic              cmd_valid;
  logic              flag_zero = 1'b0;
  logic              flag_carry = 1'b0;

  logic [WORD_W-1:0] mem [256];
  assign cs_data = mem[cs_addr[7:0]];

  always #4 clk = ~clk;

  useq_pipe u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_addr    (cs_addr),
    .cs_data    (cs_data),
    .cmd        (cmd),
    .cmd_valid  (cmd_valid),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;
  bit rand_flags = 1'b0;

  // reference model state
  logic [ADDR_W-1:0] m_csar, m_pc;
  logic [WORD_W-1:0] m_ir;
  bit    m_val, m_z, m_c, m_skipped;
  int    hold;
  string m_atag, m_vtag;

  function automatic logic [31:0] enc(input logic [15:0] c, input logic [3:0] n,
                                      input logic [11:0] a);
    return {c, n, a};
  endfunction

  function automatic bit cond_ok(input logic [1:0] cd, input bit z, input bit c);
    case (cd)
      2'b00:   return 1'b1;
      2'b01:   return z;
      2'b10:   return c;
      default: return !z;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_csar = '0; m_pc = '0; m_ir = '0;
    m_val = 0; m_z = 0; m_c = 0; m_skipped = 0;
    m_atag = "R1"; m_vtag = "R1";
  endtask

  task automatic check_outputs();
    check(cs_addr == m_csar, m_atag, "cs_addr", 32'(cs_addr), 32'(m_csar));
    check(cmd_valid == m_val, m_vtag, "cmd_valid", 32'(cmd_valid), 32'(m_val));
    check(cmd == m_ir[31:16], m_vtag, "cmd", 32'(cmd), 32'(m_ir[31:16]));
  endtask

  task automatic step(input bit z_in, input bit c_in);
    logic [WORD_W-1:0] w;
    logic [1:0]        mode, cd;
    logic [ADDR_W-1:0] tgt, nxt_csar;
    bit                is_jump, tk;
    if (hold > 0) begin
      hold--;
      return;
    end
    w       = mem[m_csar[7:0]];
    mode    = m_ir[13:12];
    cd      = m_ir[15:14];
    tgt     = m_ir[11:0];
    is_jump = (mode == 2'b01) || (mode == 2'b10);
    tk      = m_val && is_jump && cond_ok(cd, m_z, m_c);
    if (!m_val)                m_atag = "R6";
    else if (tk && cd != 2'b00) m_atag = "R7";
    else if (tk)               m_atag = (mode == 2'b01) ? "R3" : "R4";
    else if (is_jump)          m_atag = m_skipped ? "R8" : "R10";
    else if (mode == 2'b11)    m_atag = "R9";
    else                       m_atag = "R2";
    m_vtag = tk ? "R5" : (is_jump && m_val ? "R10" : "R2");
    nxt_csar = tk ? ((mode == 2'b01) ? tgt : ADDR_W'(m_pc + tgt)) : ADDR_W'(m_csar + 1'b1);
    m_skipped = !m_val;
    if (m_val) begin m_z = z_in; m_c = c_in; end
    m_ir   = tk ? '0 : w;
    m_val  = !tk;
    m_pc   = m_csar;
    m_csar = nxt_csar;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      check_outputs();
      if (rand_flags) begin
        flag_zero  = 1'($urandom);
        flag_carry = 1'($urandom);
      end else begin
        // pseudo datapath: flags from the command, all ones in dead slots
        flag_zero  = cmd_valid ? cmd[0] : 1'b1;
        flag_carry = cmd_valid ? cmd[1] : 1'b1;
      end
      step(flag_zero, flag_carry);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    model_reset();
    hold = 0;
    for (int i = 0; i < 3; i++) begin
      check_outputs();  // R1 reset values
      @(negedge clk);
    end
    rst_n = 1'b1;
    hold = 2;           // R1 synchronizer latency
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // directed program: shadows hold far jumps that must be ignored
    mem[1]  = enc(16'h0000, 4'b0001, 12'd10);   // JMP abs 10, R3
    mem[2]  = enc(16'h0000, 4'b0001, 12'd200);  // shadow, R5 R6
    mem[10] = enc(16'h0000, 4'b0101, 12'd50);   // JZ abs after dead slot, R8
    mem[11] = enc(16'h0003, 4'b0000, 12'd0);    // sets zero and carry
    mem[12] = enc(16'h0000, 4'b1010, 12'h010);  // JC rel +16 -> 28, R4 R7
    mem[13] = enc(16'h0000, 4'b0001, 12'd300);  // shadow
    mem[28] = enc(16'h0001, 4'b1101, 12'd60);   // JNZ abs 60, own zero ignored, R7
    mem[29] = enc(16'h0000, 4'b0001, 12'd400);  // shadow
    mem[60] = enc(16'h0002, 4'b0011, 12'd5);    // spare mode steps, R9
    mem[61] = enc(16'h0000, 4'b0010, 12'hFFF);  // JMP rel -1 -> 60
    mem[62] = enc(16'hFFFF, 4'b0001, 12'd7);    // shadow
    @(negedge clk);
    do_reset();
    run(40);

    // random phase
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    rand_flags = 1'b1;
    do_reset();
    run(4000);

    // reset during activity, then random again with a new store
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    do_reset();
    run(1500);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule